// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This core keeps the time of day and the calendar date as packed BCD words. A prescaler counts pulses of a 32768 Hz slow-clock enable and produces one tick per second. Each tick advances seconds, minutes and hours. When the day rolls over it also advances the weekday, the day of month, the month, the year and the century. Hours run in 24-hour form or in 12-hour form with an afternoon flag. The supported dates run from 1900 through 2099, and after the last day of 2099 the date wraps back to 1900.

Software reaches the core through a single-cycle register port. To change the time or the date, software sets a request bit in the control word. Counting then stops, and one cycle later the core raises an acknowledge. While the acknowledge is up, the core takes new time or calendar words. A word that is not valid BCD or is out of range is refused and flagged in a validity word. When software clears all request bits, counting resumes from the stored values. The per-second, minute-change and day-change pulses go to a separate status block.

Top module: `rtcCore`

## Requirements
- R1: After reset the time word reads 0x00000000 (00:00:00), the calendar word reads 0x01210020 (2000-01-01, weekday 1), and the control, mode and validity words read 0. The updAck output is low.
- R2: The control word is at offset 0x00. Bit 0 requests a time update and bit 1 requests a calendar update. While either bit is set, no second tick occurs and the time and calendar words do not change except by accepted writes.
- R3: updAck goes high on the clock edge after a request bit becomes set. It goes low on the clock edge after all request bits are cleared.
- R4: A write to the time word (offset 0x08) takes effect only while control bit 0 is set and updAck is high. A write to the calendar word (offset 0x0C) takes effect only while control bit 1 is set and updAck is high. Any other write to these words is ignored.
- R5: The time word holds seconds in BCD at bits 6:0, minutes in BCD at bits 14:8, hours in BCD at bits 21:16, and the afternoon flag at bit 22. In 24-hour mode the sequence 23:59:59 is followed by 00:00:00 and a day advance.
- R6: Setting mode word bit 0 (offset 0x04) selects 12-hour mode, with hours 01..12 and bit 22 set for afternoon. In this mode 11:59:59 is followed by 12:00:00 with the flag toggled, and 12:59:59 is followed by 01:00:00. The day advances when 11:59:59 with the flag set rolls over.
- R7: The calendar word holds the century in BCD at bits 6:0, the year in BCD at bits 15:8, the month 1..12 in BCD at bits 20:16, the weekday 1..7 at bits 23:21, and the day of month in BCD at bits 29:24. April, June, September and November have 30 days; February has 29 in years divisible by 4 and 28 otherwise; the other months have 31.
- R8: December 31 rolls over to January 1 of the next year. Year 1999 is followed by 2000, and year 2099 is followed by 1900. Weekday 7 is followed by weekday 1.
- R9: The validity word is at offset 0x2C. Bit 0 is set when an accepted-window time write was refused and bit 1 is set when a calendar write was refused. A write is refused when a field holds a digit above 9, or when it is out of range: seconds or minutes above 59; hours above 23 or the flag set in 24-hour mode; hours outside 01..12 in 12-hour mode; a century other than 19 or 20; a month outside 1..12; a weekday of 0; or a day of month outside 1 to the length of that month. A refused write leaves the register unchanged. A later accepted write clears its bit. Bits 3:2 read 0.
- R10: A second tick occurs on every 2^PRE_W-th slowTick pulse. The prescaler is held at zero while any request bit is set, so the first tick comes exactly 2^PRE_W slowTick pulses after release. No tick occurs without slowTick pulses.
- R11: secEvent pulses for one cycle on each second tick. timeEvent pulses on ticks that change the minute. calEvent pulses on ticks that change the date. Each pulse is visible in the same cycle as the new register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | One-cycle enable at the 32768 Hz slow-clock rate |
| addr | input | ADDR_W | Register byte offset |
| wrEn | input | 1 | Write strobe for the addressed register |
| wData | input | 32 | Write data |
| rData | output | 32 | Read data of the addressed register (combinational) |
| updAck | output | 1 | Counting frozen for an update; new words are accepted |
| secEvent | output | 1 | One-cycle pulse on each second tick |
| timeEvent | output | 1 | One-cycle pulse when the minute changes |
| calEvent | output | 1 | One-cycle pulse when the date changes |

## Verification
The hardest cases to reach are the carry chains that span several fields at once. Examples are a leap-day February end, the century wrap from 2099 to 1900, and the 12-hour afternoon-to-midnight day advance. Waiting for any of these in real time would take years. The bench uses the update handshake to load a word that sits one second before each boundary, releases the freeze, waits for the single resulting tick and compares the full words and event pulses. A reduced prescaler width keeps each second to a few cycles, and refused-write and ignored-write cases are checked while the core is still frozen, so nothing moves under the check.

// File: rtl/rtcPkg.sv
package rtcPkg;

  localparam int DATA_W = 32;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MODE  = 8'h04;
  localparam logic [7:0] OFS_TIME  = 8'h08;
  localparam logic [7:0] OFS_CAL   = 8'h0C;
  localparam logic [7:0] OFS_VALID = 8'h2C;

  localparam logic [31:0] TIME_MASK  = 32'h007F_7F7F;
  localparam logic [31:0] CAL_MASK   = 32'h3FFF_FF7F;
  localparam logic [31:0] CAL_RESET  = 32'h0121_0020;

  typedef struct packed {
    logic tick;
    logic loadTime;
    logic loadCal;
    logic hour12;
  } dpStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic digitsOk(input logic [7:0] v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  function automatic logic [7:0] monthDays(input logic [7:0] mon, input logic [7:0] yr);
    logic leap;
    leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                 : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic timeOk(input logic [31:0] w, input logic h12);
    logic [7:0] s, m, h;
    s = {1'b0, w[6:0]};
    m = {1'b0, w[14:8]};
    h = {2'b0, w[21:16]};
    if (!(digitsOk(s) && digitsOk(m) && digitsOk(h))) return 1'b0;
    if (s > 8'h59 || m > 8'h59) return 1'b0;
    if (h12) return (h >= 8'h01) && (h <= 8'h12);
    return (h <= 8'h23) && !w[22];
  endfunction

  function automatic logic calOk(input logic [31:0] w);
    logic [7:0] c, y, mo, d;
    c  = {1'b0, w[6:0]};
    y  = w[15:8];
    mo = {3'b0, w[20:16]};
    d  = {2'b0, w[29:24]};
    if (!(digitsOk(c) && digitsOk(y) && digitsOk(mo) && digitsOk(d))) return 1'b0;
    if (c != 8'h19 && c != 8'h20) return 1'b0;
    if (mo < 8'h01 || mo > 8'h12) return 1'b0;
    if (w[23:21] == 3'd0) return 1'b0;
    return (d >= 8'h01) && (d <= monthDays(mo, y));
  endfunction

endpackage

// File: rtl/rtcCtrl.sv
module rtcCtrl
  import rtcPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PRE_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [1:0]        cmdBits,
  output logic [1:0]        ctrlReg,
  output logic              hour12,
  output logic              updAck,
  output dpStrobe_t         st
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFS_TIME);
  localparam logic [ADDR_W-1:0] A_CAL  = ADDR_W'(OFS_CAL);

  logic [PRE_W-1:0] presc;
  logic             anyReq;

  assign anyReq = |ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      hour12  <= 1'b0;
      updAck  <= 1'b0;
      presc   <= '0;
    end else begin
      if (wrEn && addr == A_CTRL) ctrlReg <= cmdBits;
      if (wrEn && addr == A_MODE) hour12  <= cmdBits[0];
      updAck <= anyReq;
      if (anyReq)        presc <= '0;
      else if (slowTick) presc <= presc + 1'b1;
    end
  end

  always_comb begin
    st.tick     = slowTick && !anyReq && (presc == '1);
    st.loadTime = wrEn && (addr == A_TIME) && ctrlReg[0] && updAck;
    st.loadCal  = wrEn && (addr == A_CAL)  && ctrlReg[1] && updAck;
    st.hour12   = hour12;
  end

  // R3
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |=> updAck);

  // R3
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |=> !updAck);

  // R10
  presc_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |=> (presc == '0));

endmodule

// File: rtl/rtcDatapath.sv
module rtcDatapath
  import rtcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] timeReg,
  output logic [DATA_W-1:0] calReg,
  output logic              nvTime,
  output logic              nvCal,
  output logic              secEvent,
  output logic              timeEvent,
  output logic              calEvent
);

  logic [6:0] sec, mnt, cent, nSec, nMin, nCent;
  logic [5:0] hr, dt, nHr, nDt;
  logic [4:0] mon, nMon;
  logic [7:0] yr, nYr;
  logic [2:0] wd, nWd;
  logic       pm, nPm;
  logic       secWrap, hourStep, dayStep, monthStep, yearStep, centStep;
  logic [DATA_W-1:0] nextTime, nextCal;

  always_comb begin
    sec  = timeReg[6:0];
    mnt  = timeReg[14:8];
    hr   = timeReg[21:16];
    pm   = timeReg[22];
    cent = calReg[6:0];
    yr   = calReg[15:8];
    mon  = calReg[20:16];
    wd   = calReg[23:21];
    dt   = calReg[29:24];

    secWrap  = (sec == 7'h59);
    hourStep = secWrap && (mnt == 7'h59);
    nSec = secWrap ? 7'h00 : 7'(bcdInc({1'b0, sec}));
    nMin = !secWrap ? mnt : (hourStep ? 7'h00 : 7'(bcdInc({1'b0, mnt})));

    nHr = hr;
    nPm = pm;
    dayStep = 1'b0;
    if (hourStep) begin
      if (st.hour12) begin
        if (hr == 6'h11) begin
          nHr = 6'h12;
          nPm = !pm;
          dayStep = pm;
        end else if (hr == 6'h12) begin
          nHr = 6'h01;
        end else begin
          nHr = 6'(bcdInc({2'b0, hr}));
        end
      end else if (hr == 6'h23) begin
        nHr = 6'h00;
        dayStep = 1'b1;
      end else begin
        nHr = 6'(bcdInc({2'b0, hr}));
      end
    end

    monthStep = dayStep && ({2'b0, dt} == monthDays({3'b0, mon}, yr));
    yearStep  = monthStep && (mon == 5'h12);
    centStep  = yearStep && (yr == 8'h99);

    nWd   = !dayStep ? wd : ((wd == 3'd7) ? 3'd1 : wd + 3'd1);
    nDt   = monthStep ? 6'h01 : (dayStep ? 6'(bcdInc({2'b0, dt})) : dt);
    nMon  = yearStep ? 5'h01 : (monthStep ? 5'(bcdInc({3'b0, mon})) : mon);
    nYr   = centStep ? 8'h00 : (yearStep ? bcdInc(yr) : yr);
    nCent = !centStep ? cent : ((cent == 7'h19) ? 7'h20 : 7'h19);

    nextTime = {9'd0, nPm, nHr, 1'b0, nMin, 1'b0, nSec};
    nextCal  = {2'd0, nDt, nWd, nMon, nYr, 1'b0, nCent};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeReg   <= '0;
      calReg    <= CAL_RESET;
      nvTime    <= 1'b0;
      nvCal     <= 1'b0;
      secEvent  <= 1'b0;
      timeEvent <= 1'b0;
      calEvent  <= 1'b0;
    end else begin
      secEvent  <= st.tick;
      timeEvent <= st.tick && secWrap;
      calEvent  <= st.tick && dayStep;
      if (st.tick) begin
        timeReg <= nextTime;
        calReg  <= nextCal;
      end
      if (st.loadTime) begin
        nvTime <= !timeOk(wData, st.hour12);
        if (timeOk(wData, st.hour12)) timeReg <= wData & TIME_MASK;
      end
      if (st.loadCal) begin
        nvCal <= !calOk(wData);
        if (calOk(wData)) calReg <= wData & CAL_MASK;
      end
    end
  end

  // R2
  time_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.tick && !st.loadTime) |=> $stable(timeReg));

  // R2
  cal_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.tick && !st.loadCal) |=> $stable(calReg));

  // R11
  sec_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.tick |=> secEvent);

  // R11
  cal_needs_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    calEvent |-> timeEvent);

  // R5
  sec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeReg[6:0] <= 7'h59);

endmodule

// File: rtl/rtcCore.sv
module rtcCore
  import rtcPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PRE_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wData,
  output logic [31:0]       rData,
  output logic              updAck,
  output logic              secEvent,
  output logic              timeEvent,
  output logic              calEvent
);

  dpStrobe_t   st;
  logic [1:0]  ctrlReg;
  logic        hour12, nvTime, nvCal;
  logic [31:0] timeReg, calReg;

  rtcCtrl #(.ADDR_W(ADDR_W), .PRE_W(PRE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .addr(addr), .wrEn(wrEn),
    .cmdBits(wData[1:0]), .ctrlReg(ctrlReg), .hour12(hour12),
    .updAck(updAck), .st(st)
  );

  rtcDatapath uData (
    .clk(clk), .rstN(rstN), .st(st), .wData(wData),
    .timeReg(timeReg), .calReg(calReg), .nvTime(nvTime), .nvCal(nvCal),
    .secEvent(secEvent), .timeEvent(timeEvent), .calEvent(calEvent)
  );

  always_comb begin
    rData = '0;
    if (addr == ADDR_W'(OFS_CTRL))  rData = {30'd0, ctrlReg};
    if (addr == ADDR_W'(OFS_MODE))  rData = {31'd0, hour12};
    if (addr == ADDR_W'(OFS_TIME))  rData = timeReg;
    if (addr == ADDR_W'(OFS_CAL))   rData = calReg;
    if (addr == ADDR_W'(OFS_VALID)) rData = {28'd0, 2'b00, nvCal, nvTime};
  end

endmodule

// File: tb/rtcCore_test.sv
module rtcCore_test;

  localparam int PRE_W  = 3;
  localparam int PERIOD = 1 << PRE_W;
  localparam int NVEC   = 11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowTick = 1'b1;
  logic [5:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wData = '0;
  logic [31:0] rData;
  logic        updAck, secEvent, timeEvent, calEvent;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  rtcCore #(.ADDR_W(6), .PRE_W(PRE_W)) uut (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .addr(addr), .wrEn(wrEn),
    .wData(wData), .rData(rData), .updAck(updAck), .secEvent(secEvent),
    .timeEvent(timeEvent), .calEvent(calEvent)
  );

  // {mode, timeIn, calIn, timeOut, calOut, timeEv, calEv}
  localparam logic [130:0] VECS [NVEC] = '{
    {1'b0, 32'h00123456, 32'h15652420, 32'h00123457, 32'h15652420, 1'b0, 1'b0},
    {1'b0, 32'h00105959, 32'h15652420, 32'h00110000, 32'h15652420, 1'b1, 1'b0},
    {1'b0, 32'h00235959, 32'h28622420, 32'h00000000, 32'h29822420, 1'b1, 1'b1},
    {1'b0, 32'h00235959, 32'h28422320, 32'h00000000, 32'h01632320, 1'b1, 1'b1},
    {1'b0, 32'h00235959, 32'h31F29919, 32'h00000000, 32'h01210020, 1'b1, 1'b1},
    {1'b0, 32'h00235959, 32'h31929920, 32'h00000000, 32'h01A10019, 1'b1, 1'b1},
    {1'b0, 32'h00235959, 32'h30242420, 32'h00000000, 32'h01452420, 1'b1, 1'b1},
    {1'b1, 32'h00115959, 32'h15652420, 32'h00520000, 32'h15652420, 1'b1, 1'b0},
    {1'b1, 32'h00525959, 32'h15652420, 32'h00410000, 32'h15652420, 1'b1, 1'b0},
    {1'b1, 32'h00515959, 32'h15652420, 32'h00120000, 32'h16852420, 1'b1, 1'b1},
    {1'b0, 32'h00235959, 32'h31612420, 32'h00000000, 32'h01822420, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rData;
  endtask

  // returns number of negedges until secEvent seen (limit -> 999)
  task automatic waitSec(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!secEvent && n < 200);
    if (!secEvent) n = 999;
  endtask

  task automatic freeze(input logic [1:0] bits);
    wr(6'h00, {30'd0, bits});
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h08, v); check("R1 time", v, 32'h0);
    rd(6'h0C, v); check("R1 cal", v, 32'h01210020);
    rd(6'h00, v); check("R1 ctrl", v, 32'h0);
    rd(6'h04, v); check("R1 mode", v, 32'h0);
    rd(6'h2C, v); check("R1 valid", v, 32'h0);
    check("R1 ack", {31'd0, updAck}, 32'h0);

    // Vector table: R5 R6 R7 R8 R11
    for (int i = 0; i < NVEC; i++) begin
      logic [130:0] t;
      t = VECS[i];
      wr(6'h04, {31'd0, t[130]});
      freeze(2'b11);
      wr(6'h08, t[129:98]);
      wr(6'h0C, t[97:66]);
      wr(6'h00, 32'h0);
      waitSec(n);
      check($sformatf("R11 vec%0d secEvent", i), {31'd0, secEvent}, 32'h1);
      check($sformatf("R11 vec%0d timeEvent", i), {31'd0, timeEvent}, {31'd0, t[1]});
      check($sformatf("R11 vec%0d calEvent", i), {31'd0, calEvent}, {31'd0, t[0]});
      rd(6'h08, v); check($sformatf("R5/R6 vec%0d time", i), v, t[65:34]);
      rd(6'h0C, v); check($sformatf("R7/R8 vec%0d cal", i), v, t[33:2]);
      @(negedge clk);
      check("R11 pulse width", {31'd0, secEvent}, 32'h0);
    end

    // R3 acknowledge timing
    wr(6'h04, 32'h0);
    wr(6'h00, 32'h1);
    check("R3 ack not yet", {31'd0, updAck}, 32'h0);
    @(negedge clk);
    check("R3 ack high", {31'd0, updAck}, 32'h1);
    wr(6'h00, 32'h3);
    wr(6'h08, 32'h00101010);
    wr(6'h0C, 32'h15652420);
    wr(6'h00, 32'h0);
    check("R3 ack still", {31'd0, updAck}, 32'h1);
    @(negedge clk);
    check("R3 ack low", {31'd0, updAck}, 32'h0);

    // R2 frozen: no tick, values stable
    freeze(2'b11);
    wr(6'h08, 32'h00101010);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (secEvent) n++;
    end
    check("R2 no tick frozen", n, 0);
    rd(6'h08, v); check("R2 time held", v, 32'h00101010);
    rd(6'h0C, v); check("R2 cal held", v, 32'h15652420);

    // R4 writes ignored without matching request bit
    freeze(2'b10);
    wr(6'h08, 32'h00202020);
    rd(6'h08, v); check("R4 time ignored", v, 32'h00101010);
    freeze(2'b01);
    wr(6'h0C, 32'h01210020);
    rd(6'h0C, v); check("R4 cal ignored", v, 32'h15652420);

    // R9 validity
    freeze(2'b11);
    wr(6'h08, 32'h00006000);
    rd(6'h2C, v); check("R9 sec 60 flagged", v, 32'h1);
    rd(6'h08, v); check("R9 time kept", v, 32'h00101010);
    wr(6'h08, 32'h0000005A);
    rd(6'h2C, v); check("R9 non-BCD flagged", v, 32'h1);
    wr(6'h08, 32'h00401010);
    rd(6'h2C, v); check("R9 pm in 24h flagged", v, 32'h1);
    wr(6'h08, 32'h00111111);
    rd(6'h2C, v); check("R9 valid clears", v, 32'h0);
    wr(6'h0C, 32'h30222420);
    rd(6'h2C, v); check("R9 Feb 30 flagged", v, 32'h2);
    rd(6'h0C, v); check("R9 cal kept", v, 32'h15652420);
    wr(6'h0C, 32'h29222320);
    rd(6'h2C, v); check("R9 Feb 29 non-leap flagged", v, 32'h2);
    wr(6'h0C, 32'h01212018);
    rd(6'h2C, v); check("R9 century 18 flagged", v, 32'h2);
    wr(6'h0C, 32'h29222420);
    rd(6'h2C, v); check("R9 Feb 29 leap ok", v, 32'h0);
    wr(6'h04, 32'h1);
    wr(6'h08, 32'h00000000);
    rd(6'h2C, v); check("R9 12h hour 00 flagged", v, 32'h1);
    wr(6'h04, 32'h0);
    wr(6'h08, 32'h00000000);
    rd(6'h2C, v); check("R9 24h hour 00 ok", v, 32'h0);

    // R10 prescaler period
    wr(6'h00, 32'h0);
    waitSec(n);
    check("R10 first tick", n, PERIOD);
    waitSec(n);
    check("R10 tick period", n, PERIOD);
    @(negedge clk);
    slowTick = 1'b0;
    n = 0;
    for (int k = 0; k < 3 * PERIOD; k++) begin
      @(negedge clk);
      if (secEvent) n++;
    end
    check("R10 no slowTick no tick", n, 0);
    slowTick = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule